// File: doc/BRIEF.md
# UART Baud Clock Source Generator

This block produces the bit-timing enables that a UART transmitter and receiver run from. It picks one of three clock sources. The bus clock can be divided first by a fixed prescaler of 32 and then by a 16-bit programmable count. An external timer-input pin can serve as a 16x oversampling clock, which makes it an asynchronous source. The same pin can also be used undivided, so that each pin edge marks one bit time for synchronous operation. A fourth select code turns all enables off.

The outputs are single-cycle enables in the bus clock domain. The first is a 16x oversampling enable for asynchronous framing. The second is a 1x bit enable, which in the oversampling modes coincides with every sixteenth oversampling enable. A third output tells the neighbouring timer that the pin is claimed, so the timer's input capture path can be gated off.

The external pin passes through a two-stage synchronizer, and its rising edges are then detected. For that reason the pin frequency must stay below about a quarter of the bus clock. Writing the select field or either divider byte restarts the prescaler, the divider and the oversample counter from zero.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst_n` is low, `os16En` and `bitEn` are both low.
- R2: With `clkSel` = 2'b00 (bus source), `os16En` pulses once every 32·D bus cycles, where D = {`divHi`,`divLo`}.
- R3: `divHi` is the upper byte of D and `divLo` the lower byte, so `divHi`=1, `divLo`=0 gives D = 256.
- R4: A divider value D = 0 behaves exactly like D = 1.
- R5: With `clkSel` = 2'b00 or 2'b01, `bitEn` pulses in the same cycle as every sixteenth `os16En` pulse, and never without `os16En`.
- R6: With `clkSel` = 2'b01 (pin as 16x clock), `os16En` pulses once per rising edge of `extPin`, so the pulse spacing equals the pin period.
- R7: With `clkSel` = 2'b10 (pin as 1x clock), `bitEn` pulses once per rising edge of `extPin` and `os16En` stays low.
- R8: With `clkSel` = 2'b11 (off), neither enable ever pulses.
- R9: `pinInUse` is high exactly when `clkSel` is 2'b01 or 2'b10, and it follows `clkSel` within the same cycle.
- R10: A change of `clkSel`, `divHi` or `divLo` restarts all counters at the first clock edge that sees the change. Neither enable is high in the cycle after that edge. In bus mode the first `os16En` goes high right after the edge 32·D edges later.
- R11: Each enable pulse lasts exactly one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extPin | input | 1 | Asynchronous external clock pin |
| clkSel | input | 2 | Source select: 00 bus, 01 pin/16, 10 pin 1x, 11 off |
| divHi | input | 8 | Upper byte of the 16-bit divider |
| divLo | input | 8 | Lower byte of the 16-bit divider |
| os16En | output | 1 | 16x oversampling enable, one bus cycle wide |
| bitEn | output | 1 | 1x bit enable, one bus cycle wide |
| pinInUse | output | 1 | The pin is claimed by the UART; gates off timer capture |

## Verification
On every cycle the assertions check several properties. Both enables are one cycle wide, and a restart leaves both low in the following cycle. A bit enable outside the 1x pin mode always lands on an oversampling enable. The 1x pin mode never raises the oversampling enable, and the off mode keeps both enables low. The assertions cannot show the actual pulse spacings: 32·D for several D, including the zero and upper-byte cases, the pin-period spacing, and the sixteen-to-one ratio. The exact latency from a configuration change to the first enable is also beyond them. The bench scenarios measure all of these in bus cycles.

// File: rtl/baud_src_pkg.sv
package baud_src_pkg;

  typedef enum logic [1:0] {
    SRC_BUS   = 2'b00,
    SRC_PIN16 = 2'b01,
    SRC_PIN1  = 2'b10,
    SRC_OFF   = 2'b11
  } srcMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     restart;
    logic     pinEdge;
    srcMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/baud_src_ctrl.sv
module baud_src_ctrl
  import baud_src_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extPin,
  input  logic [1:0]        clkSel,
  input  logic [DIV_W-1:0]  divWord,
  output ctrlStrobe_t       strobe
);

  localparam int CFG_W = DIV_W + 2;

  logic [CFG_W-1:0]     cfgQ;
  logic [CFG_W-1:0]     cfgNow;
  logic [SYNC_STAGES:0] syncQ;
  logic                 cfgChanged;

  assign cfgNow     = {clkSel, divWord};
  assign cfgChanged = (cfgNow != cfgQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ  <= '0;
      syncQ <= '0;
    end else begin
      cfgQ  <= cfgNow;
      syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
    end
  end

  always_comb begin
    strobe.restart = cfgChanged;
    strobe.pinEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    strobe.mode    = srcMode_e'(cfgQ[CFG_W-1 -: 2]);
  end

  initial begin
    assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
  end

  // a detected pin edge is never followed directly by another (R6, R7)
  assert_edge_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pinEdge |=> !strobe.pinEdge);

endmodule

// File: rtl/baud_src_dp.sv
module baud_src_dp
  import baud_src_pkg::*;
#(
  parameter int PRESCALE   = 32,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [DIV_W-1:0] divWord,
  output logic             os16En,
  output logic             bitEn
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int OS_W  = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

  logic [PRE_W-1:0] presc;
  logic [DIV_W-1:0] divCnt;
  logic [OS_W-1:0]  osCnt;
  logic [DIV_W-1:0] divEff;
  logic             prescTick;
  logic             busFire;
  logic             os16Fire;
  logic             osWrap;
  logic             bitFire;

  always_comb begin
    divEff    = (divWord == '0) ? DIV_W'(1) : divWord;
    prescTick = (presc == PRE_W'(PRESCALE - 1));
    busFire   = prescTick && (divCnt == divEff - DIV_W'(1));
    osWrap    = (osCnt == OS_W'(OVERSAMPLE - 1));
    unique case (strobe.mode)
      SRC_BUS:   os16Fire = busFire;
      SRC_PIN16: os16Fire = strobe.pinEdge;
      default:   os16Fire = 1'b0;
    endcase
    if (strobe.mode == SRC_PIN1) bitFire = strobe.pinEdge;
    else                         bitFire = os16Fire && osWrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.restart) begin
      presc  <= '0;
      divCnt <= '0;
      osCnt  <= '0;
      os16En <= 1'b0;
      bitEn  <= 1'b0;
    end else begin
      presc <= prescTick ? '0 : presc + PRE_W'(1);
      if (prescTick) divCnt <= busFire ? '0 : divCnt + DIV_W'(1);
      if (os16Fire)  osCnt  <= osWrap ? '0 : osCnt + OS_W'(1);
      os16En <= os16Fire;
      bitEn  <= bitFire;
    end
  end

  assert_os_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    os16En |=> !os16En);
  assert_bit_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bitEn |=> !bitEn);
  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restart |=> (!os16En && !bitEn));
  assert_bit_on_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bitEn && strobe.mode != SRC_PIN1) |-> os16En);
  assert_pin1_no_os_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.mode == SRC_PIN1) |-> !os16En);
  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.mode == SRC_OFF) |-> !(os16En || bitEn));

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_src_pkg::*;
#(
  parameter int PRESCALE    = 32,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       extPin,
  input  logic [1:0] clkSel,
  input  logic [7:0] divHi,
  input  logic [7:0] divLo,
  output logic       os16En,
  output logic       bitEn,
  output logic       pinInUse
);

  localparam int DIV_W = 16;

  logic [DIV_W-1:0] divWord;
  ctrlStrobe_t      strobe;

  assign divWord  = {divHi, divLo};
  assign pinInUse = (srcMode_e'(clkSel) == SRC_PIN16) || (srcMode_e'(clkSel) == SRC_PIN1);

  baud_src_ctrl #(
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .extPin (extPin),
    .clkSel (clkSel),
    .divWord(divWord),
    .strobe (strobe)
  );

  baud_src_dp #(
    .PRESCALE  (PRESCALE),
    .DIV_W     (DIV_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .divWord(divWord),
    .os16En (os16En),
    .bitEn  (bitEn)
  );

endmodule

// File: tb/sim_baud_clk_gen.sv
`timescale 1ns/1ps
module sim_baud_clk_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       extPin;
  logic [1:0] clkSel;
  logic [7:0] divHi, divLo;
  logic       os16En, bitEn, pinInUse;

  int errors = 0;
  int checks = 0;
  bit pinRun = 1'b0;
  int pinHalf = 4;
  int phase = 0;

  always #4 clk = ~clk;  // 125 MHz

  baud_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .clkSel(clkSel),
    .divHi(divHi), .divLo(divLo), .os16En(os16En), .bitEn(bitEn),
    .pinInUse(pinInUse)
  );

  // pin generator: toggles only at falling bus-clock edges
  always @(negedge clk) begin
    if (!pinRun) begin
      extPin <= 1'b0;
      phase  <= 0;
    end else if (phase >= pinHalf - 1) begin
      extPin <= ~extPin;
      phase  <= 0;
    end else begin
      phase <= phase + 1;
    end
  end

  // divider table: divHi, divLo, expected os16 spacing, expected bit spacing (0 = skip)
  localparam int NV = 5;
  localparam int TBL_HI [NV]  = '{0, 0, 0, 1, 0};
  localparam int TBL_LO [NV]  = '{1, 3, 0, 0, 5};
  localparam int TBL_OS [NV]  = '{32, 96, 32, 8192, 160};
  localparam int TBL_BIT[NV]  = '{512, 1536, 512, 0, 2560};
  localparam string TBL_REQ[NV] = '{"R2", "R2", "R4", "R3", "R2"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measures cycles between two successive pulses of the chosen enable
  task automatic measureGap(input bit useBit, input int limit, output int gap);
    int n = 0;
    while (!(useBit ? bitEn : os16En) && n < limit) begin
      @(negedge clk); n++;
    end
    if (n >= limit) begin gap = -1; return; end
    @(negedge clk);
    gap = 1;
    while (!(useBit ? bitEn : os16En) && gap < limit) begin
      @(negedge clk); gap++;
    end
    if (gap >= limit) gap = -1;
  endtask

  task automatic countPulses(input int cycles, output int nOs, output int nBit);
    nOs = 0; nBit = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (os16En) nOs++;
      if (bitEn)  nBit++;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap, nOs, nBit;
    rst_n = 1'b0; clkSel = 2'b00; divHi = 8'd0; divLo = 8'd1;
    repeat (40) @(negedge clk);
    // R1: quiet in reset
    check(os16En == 1'b0, "R1", int'(os16En), 0);
    check(bitEn == 1'b0, "R1", int'(bitEn), 0);
    check(pinInUse == 1'b0, "R9", int'(pinInUse), 0);
    rst_n = 1'b1;

    // table walk in bus mode (R2, R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      divHi = 8'(TBL_HI[i]); divLo = 8'(TBL_LO[i]);
      measureGap(1'b0, TBL_OS[i] * 3, gap);
      check(gap == TBL_OS[i], TBL_REQ[i], gap, TBL_OS[i]);
      if (TBL_BIT[i] != 0) begin
        measureGap(1'b1, TBL_BIT[i] * 2 + 64, gap);
        check(gap == TBL_BIT[i], "R5", gap, TBL_BIT[i]);
      end
    end

    // R10: restart latency, D=2 -> first pulse 65 falling edges after the write
    @(negedge clk); divHi = 8'd0; divLo = 8'd1;
    repeat (100) @(negedge clk);
    divLo = 8'd2;
    begin
      int n = 0;
      while (n < 300) begin
        @(negedge clk); n++;
        if (os16En) break;
      end
      check(n == 65, "R10", n, 65);
    end

    // R6: pin as 16x clock
    pinHalf = 4; pinRun = 1'b1;
    @(negedge clk); clkSel = 2'b01;
    #1 check(pinInUse == 1'b1, "R9", int'(pinInUse), 1);
    measureGap(1'b0, 100, gap);
    check(gap == 8, "R6", gap, 8);
    measureGap(1'b1, 400, gap);
    check(gap == 128, "R5", gap, 128);
    while (!os16En) @(negedge clk);
    @(negedge clk);
    check(os16En == 1'b0, "R11", int'(os16En), 0);
    pinHalf = 6;
    repeat (40) @(negedge clk);
    measureGap(1'b0, 100, gap);
    check(gap == 12, "R6", gap, 12);

    // R7: pin as 1x clock
    @(negedge clk); clkSel = 2'b10;
    #1 check(pinInUse == 1'b1, "R9", int'(pinInUse), 1);
    measureGap(1'b1, 100, gap);
    check(gap == 12, "R7", gap, 12);
    countPulses(240, nOs, nBit);
    check(nOs == 0, "R7", nOs, 0);
    check(nBit == 20, "R7", nBit, 20);

    // R8: off
    @(negedge clk); clkSel = 2'b11;
    #1 check(pinInUse == 1'b0, "R9", int'(pinInUse), 0);
    countPulses(600, nOs, nBit);
    check(nOs + nBit == 0, "R8", nOs + nBit, 0);

    // back to bus: pin released
    @(negedge clk); clkSel = 2'b00; pinRun = 1'b0;
    #1 check(pinInUse == 1'b0, "R9", int'(pinInUse), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule